// File: doc/BRIEF.md
# IDE Command Strobe Timing Generator

This block drives the read and write command strobes of one IDE channel that serves two drive positions. Each position holds its own 16-bit timing word. The word sets how many base clocks the strobe stays asserted (the active phase) and how many base clocks it then stays released (the recovery phase). Both counts are stored as the count minus one, so a field of zero still gives one clock. The base clock is meant to have a 30 ns period, and software converts nanosecond figures to whole clocks by rounding up.

A channel-wide enable selects where the timing comes from. When the enable is set, the programmed per-drive word is used. When it is clear, a slow, safe default of 6 active and 14 recovery clocks is forced, whatever the words contain. A timing word can also ask the block to stretch the active phase while the device holds its ready line low. A stall counter bounds that stretch. If the device stays not-ready too long, the cycle is ended and flagged as an error.

A transfer begins with a request pulse that carries a drive select and a direction. The block takes the request only while idle and then runs the active and recovery phases. It signals the end of the transfer with a one-clock done pulse.

Top module: `ide_strobe_timer`

## Requirements
- R1: After reset, both strobes are released (high), busy, done and err are low, both timing words are 0x0000, and the channel enable is clear.
- R2: The active field is bits 15:8 and the recovery field is bits 6:0 of a timing word. A field value N gives N+1 clocks. The strobe is asserted from the clock after the accepting edge for exactly active+1 clocks. It is then released for recovery+1 clocks, during which busy stays high.
- R3: A configuration write to address 0 or 1 loads the timing word of drive 0 or drive 1. A write to address 2 loads the channel enable from data bit 0. The request's drive select (0 or 1) chooses which word a transfer uses.
- R4: While the channel enable is clear, every transfer uses 6 active and 14 recovery clocks with no ready wait, regardless of the stored words.
- R5: A recovery field of zero (for example the word 0x0200) gives exactly one recovery clock after three active clocks.
- R6: Bit 7 of a timing word enables the ready wait. The ready input is sampled at each clock edge. When bit 7 is set, the active phase continues past its programmed length until ready is sampled high. When bit 7 is clear, ready has no effect.
- R7: The ready wait adds at most STALL_MAX clocks (default 16) to the active phase. When that limit is reached, the cycle moves on to recovery, and err is high together with done for that transfer.
- R8: done is high for exactly one clock, in the first idle clock after the last recovery clock. busy is low in that same clock.
- R9: A request made while busy is ignored. A configuration write made during a transfer does not change the transfer in progress, and takes effect for the next one.
- R10: A read request (wr = 0) asserts only rd_n, and a write request asserts only wr_n. The two strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0: drive 0 word, 1: drive 1 word, 2: channel enable |
| cfg_wdata | input | 16 | Configuration write data |
| req | input | 1 | Transfer request, taken only when idle |
| req_drive | input | 1 | Drive position of the request |
| req_wr | input | 1 | 1 = write transfer, 0 = read transfer |
| iordy | input | 1 | Device ready, synchronous to clk |
| rd_n | output | 1 | Read command strobe, active low |
| wr_n | output | 1 | Write command strobe, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| err | output | 1 | Ready-wait timeout, valid with done |

## Verification
The hardest state to reach from the ports is the ready-wait timeout. It needs a word with the wait bit set and a ready line held low for more than STALL_MAX clocks past the programmed active count. The stimulus holds ready low across a short word so that the active phase runs into the cap, and a separate transfer releases ready part way through to check that the stretch ends in the right clock. A second hard case is a request and a configuration write injected in the middle of an active phase. The stimulus places both on the second strobe clock and then checks that the running transfer keeps its length and that the next transfer uses the new word.

// File: rtl/ide_strobe_pkg.sv
package ide_strobe_pkg;

    localparam int TWORD_W = 16;

    // Field layout of a per-drive timing word (minus-one counts).
    typedef struct packed {
        logic [7:0] act_m1;   // strobe asserted for act_m1+1 clocks
        logic       wait_en;  // stretch active phase while ready is low
        logic [6:0] rec_m1;   // strobe released for rec_m1+1 clocks
    } tword_t;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    // Forced word used while the channel enable is clear.
    function automatic tword_t make_default(input int act_clks, input int rec_clks);
        tword_t w;
        w.act_m1  = 8'(act_clks - 1);
        w.wait_en = 1'b0;
        w.rec_m1  = 7'(rec_clks - 1);
        return w;
    endfunction

endpackage

// File: rtl/ide_timing_regs.sv
module ide_timing_regs
    import ide_strobe_pkg::*;
#(
    parameter int NUM_DRIVES = 2,
    parameter int AW         = 2,
    parameter logic [TWORD_W-1:0] RESET_WORD = '0
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cfg_we,
    input  logic [AW-1:0]                       cfg_addr,
    input  logic [TWORD_W-1:0]                  cfg_wdata,
    output logic [NUM_DRIVES-1:0][TWORD_W-1:0]  words,
    output logic                                chan_en
);

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= RESET_WORD;
            else if (cfg_we && cfg_addr == AW'(g))
                words[g] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            chan_en <= 1'b0;
        else if (cfg_we && cfg_addr == AW'(NUM_DRIVES))
            chan_en <= cfg_wdata[0];
    end

endmodule

// File: rtl/ide_timing_sel.sv
module ide_timing_sel
    import ide_strobe_pkg::*;
#(
    parameter int NUM_DRIVES = 2,
    parameter int DW         = 1,
    parameter int DEF_ACT    = 6,
    parameter int DEF_REC    = 14
) (
    input  logic [NUM_DRIVES-1:0][TWORD_W-1:0] words,
    input  logic                               chan_en,
    input  logic [DW-1:0]                      drive,
    output tword_t                             eff
);

    localparam tword_t DEF_WORD = make_default(DEF_ACT, DEF_REC);

    tword_t raw;

    always_comb begin
        raw = tword_t'(words[drive]);
        eff = chan_en ? raw : DEF_WORD;
    end

endmodule

// File: rtl/ide_strobe_seq.sv
module ide_strobe_seq
    import ide_strobe_pkg::*;
#(
    parameter int STALL_MAX = 16,
    parameter int SW        = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  logic   req_wr,
    input  tword_t tw,
    input  logic   iordy,
    output logic   busy,
    output logic   strobe_on,
    output logic   xfer_wr,
    output logic   done,
    output logic   err
);

    phase_e     phase;
    logic [7:0] cnt;
    logic [SW-1:0] stall;
    logic       wait_en_q;
    logic [6:0] rec_q;
    logic       timed_out;
    logic       holding;

    assign holding = wait_en_q && !iordy;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            stall     <= '0;
            wait_en_q <= 1'b0;
            rec_q     <= '0;
            timed_out <= 1'b0;
            xfer_wr   <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req) begin
                        cnt       <= tw.act_m1;
                        wait_en_q <= tw.wait_en;
                        rec_q     <= tw.rec_m1;
                        xfer_wr   <= req_wr;
                        stall     <= '0;
                        timed_out <= 1'b0;
                        phase     <= PH_ACTIVE;
                    end
                end
                PH_ACTIVE: begin
                    if (cnt != 8'd0) begin
                        cnt <= cnt - 8'd1;
                    end else if (holding && stall != SW'(STALL_MAX)) begin
                        stall <= stall + SW'(1);
                    end else begin
                        timed_out <= holding;
                        cnt       <= {1'b0, rec_q};
                        phase     <= PH_RECOVER;
                    end
                end
                PH_RECOVER: begin
                    if (cnt != 8'd0) begin
                        cnt <= cnt - 8'd1;
                    end else begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                        err   <= timed_out;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign strobe_on = (phase == PH_ACTIVE);

endmodule

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer
    import ide_strobe_pkg::*;
#(
    parameter int NUM_DRIVES = 2,
    parameter int DEF_ACT    = 6,
    parameter int DEF_REC    = 14,
    parameter int STALL_MAX  = 16,
    localparam int AW = $clog2(NUM_DRIVES + 1),
    localparam int DW = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
    localparam int SW = $clog2(STALL_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [TWORD_W-1:0]  cfg_wdata,
    input  logic                req,
    input  logic [DW-1:0]       req_drive,
    input  logic                req_wr,
    input  logic                iordy,
    output logic                rd_n,
    output logic                wr_n,
    output logic                busy,
    output logic                done,
    output logic                err
);

    logic [NUM_DRIVES-1:0][TWORD_W-1:0] words;
    logic   chan_en;
    tword_t eff;
    logic   strobe_on;
    logic   xfer_wr;

    ide_timing_regs #(
        .NUM_DRIVES (NUM_DRIVES),
        .AW         (AW),
        .RESET_WORD ('0)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .words     (words),
        .chan_en   (chan_en)
    );

    ide_timing_sel #(
        .NUM_DRIVES (NUM_DRIVES),
        .DW         (DW),
        .DEF_ACT    (DEF_ACT),
        .DEF_REC    (DEF_REC)
    ) u_sel (
        .words   (words),
        .chan_en (chan_en),
        .drive   (req_drive),
        .eff     (eff)
    );

    ide_strobe_seq #(
        .STALL_MAX (STALL_MAX),
        .SW        (SW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_wr    (req_wr),
        .tw        (eff),
        .iordy     (iordy),
        .busy      (busy),
        .strobe_on (strobe_on),
        .xfer_wr   (xfer_wr),
        .done      (done),
        .err       (err)
    );

    assign rd_n = ~(strobe_on & ~xfer_wr);
    assign wr_n = ~(strobe_on &  xfer_wr);

endmodule

// File: rtl/ide_strobe_chk.sv
module ide_strobe_chk #(
    parameter int STALL_MAX = 16
) (
    input logic clk,
    input logic rst,
    input logic req,
    input logic rd_n,
    input logic wr_n,
    input logic busy,
    input logic done,
    input logic err
);

    logic rst_d;
    int   on_run;

    always_ff @(posedge clk) begin
        rst_d  <= rst;
        on_run <= (rst || (rd_n && wr_n)) ? 0 : on_run + 1;
    end

    // R1: outputs idle in the clock after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst_d |-> (rd_n && wr_n && !busy && !done && !err));

    // R10: strobes mutually exclusive
    assert_excl_strobes_R10: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R2: strobe only inside a transfer
    assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> busy);

    // R8: done lasts one clock and coincides with idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: idle request is taken
    assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> busy);

    // R7: error only with done, and strobe run bounded
    assert_err_done_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> done);
    assert_stall_cap_R7: assert property (@(posedge clk) disable iff (rst)
        on_run <= 256 + STALL_MAX);

endmodule

bind ide_strobe_timer ide_strobe_chk #(.STALL_MAX(STALL_MAX)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .rd_n (rd_n),
    .wr_n (wr_n),
    .busy (busy),
    .done (done),
    .err  (err)
);

// File: tb/sim_ide_strobe_timer.sv
module sim_ide_strobe_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        req = 1'b0;
    logic [0:0]  req_drive = '0;
    logic        req_wr = 1'b0;
    logic        iordy = 1'b1;
    logic        rd_n, wr_n, busy, done, err;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ide_strobe_timer u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req(req), .req_drive(req_drive),
        .req_wr(req_wr), .iordy(iordy), .rd_n(rd_n), .wr_n(wr_n),
        .busy(busy), .done(done), .err(err)
    );

    // ---------------- behavioural reference ----------------
    localparam int STALL = 16;
    int m_phase = 0, m_el = 0, m_stall = 0, m_act = 1, m_rec = 1;
    bit m_ie = 0, m_wr = 0, m_to = 0, m_done = 0, m_err = 0, m_en = 0, go = 0;
    int mw[2] = '{0, 0};
    int w;

    always @(posedge clk) begin
        go = 1;
        if (rst) begin
            m_phase = 0; m_el = 0; m_stall = 0; m_done = 0; m_err = 0;
            m_to = 0; m_wr = 0; m_en = 0; mw[0] = 0; mw[1] = 0;
        end else begin
            m_done = 0; m_err = 0;
            if (m_phase == 0) begin
                if (req) begin
                    w = mw[req_drive];
                    if (m_en) begin
                        m_act = (w >> 8) + 1; m_ie = ((w >> 7) & 1) == 1; m_rec = (w & 127) + 1;
                    end else begin
                        m_act = 6; m_ie = 0; m_rec = 14;
                    end
                    m_wr = req_wr; m_phase = 1; m_el = 1; m_stall = 0; m_to = 0;
                end
            end else if (m_phase == 1) begin
                if (m_el < m_act) m_el++;
                else if (m_ie && !iordy && m_stall < STALL) m_stall++;
                else begin
                    m_to = m_ie && !iordy; m_phase = 2; m_el = 1;
                end
            end else begin
                if (m_el < m_rec) m_el++;
                else begin
                    m_phase = 0; m_done = 1; m_err = m_to;
                end
            end
            if (cfg_we) begin
                if (cfg_addr < 2) mw[cfg_addr] = cfg_wdata;
                else if (cfg_addr == 2) m_en = cfg_wdata[0];
            end
        end
    end

    always @(negedge clk) begin
        if (go) begin
            bit e_rd, e_wr;
            e_rd = !(m_phase == 1 && !m_wr);
            e_wr = !(m_phase == 1 && m_wr);
            vectors++;
            if (rd_n !== e_rd || wr_n !== e_wr) begin
                fails++;
                $display("FAIL R2 strobes rd/wr=%b%b expected %b%b at %0t", rd_n, wr_n, e_rd, e_wr, $time);
            end
            if (busy !== (m_phase != 0) || done !== m_done) begin
                fails++;
                $display("FAIL R8 busy/done=%b%b expected %b%b at %0t", busy, done, (m_phase != 0), m_done, $time);
            end
            if (err !== m_err) begin
                fails++;
                $display("FAIL R7 err=%b expected %b at %0t", err, m_err, $time);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    int act_n, rec_n, saw_rd, saw_wr, err_seen;

    task automatic xfer(input bit drv, input bit wr, input int rise_at, input bit poke);
        int guard;
        act_n = 0; rec_n = 0; saw_rd = 0; saw_wr = 0; err_seen = 0;
        @(negedge clk);
        req = 1'b1; req_drive = drv; req_wr = wr;
        @(negedge clk);
        req = 1'b0;
        guard = 0;
        while (guard < 2000) begin
            if (!rd_n || !wr_n) begin
                act_n++;
                if (!rd_n) saw_rd = 1;
                if (!wr_n) saw_wr = 1;
            end else if (busy) rec_n++;
            if (done) begin
                err_seen = err;
                break;
            end
            if (rise_at > 0 && act_n == rise_at) iordy = 1'b1;
            if (poke && act_n == 2 && (!rd_n || !wr_n) && cfg_we == 1'b0 && req == 1'b0 && rec_n == 0) begin
                req = 1'b1; req_wr = !wr; cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h0000;
            end else begin
                req = 1'b0; cfg_we = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rd_n", rd_n, 1); check("R1 wr_n", wr_n, 1);
        check("R1 busy", busy, 0); check("R1 done", done, 0); check("R1 err", err, 0);

        // R2/R10: programmed read on drive 0
        cfg(2'd2, 16'h0001);
        cfg(2'd0, 16'h0303);
        xfer(1'b0, 1'b0, 0, 1'b0);
        check("R2 active", act_n, 4); check("R2 recovery", rec_n, 4);
        check("R10 rd used", saw_rd, 1); check("R10 wr unused", saw_wr, 0);
        @(negedge clk);
        check("R8 done one clock", done, 0);

        // R3/R5/R10: drive 1 write, zero recovery field
        cfg(2'd1, 16'h0200);
        xfer(1'b1, 1'b1, 0, 1'b0);
        check("R5 active", act_n, 3); check("R5 recovery", rec_n, 1);
        check("R3 drive1 word", act_n + rec_n, 4);
        check("R10 wr used", saw_wr, 1); check("R10 rd unused", saw_rd, 0);

        // R4: channel enable clear forces default
        cfg(2'd2, 16'h0000);
        xfer(1'b0, 1'b0, 0, 1'b0);
        check("R4 default active", act_n, 6); check("R4 default recovery", rec_n, 14);
        xfer(1'b1, 1'b1, 0, 1'b0);
        check("R4 default active d1", act_n, 6);

        // R6: ready wait stretches, released after 12 strobe clocks
        cfg(2'd2, 16'h0001);
        cfg(2'd0, 16'h0781);
        iordy = 1'b0;
        xfer(1'b0, 1'b0, 12, 1'b0);
        check("R6 stretched active", act_n, 12); check("R6 recovery", rec_n, 2);
        check("R6 no error", err_seen, 0);

        // R6: wait bit clear, ready low has no effect
        cfg(2'd0, 16'h0301);
        iordy = 1'b0;
        xfer(1'b0, 1'b1, 0, 1'b0);
        check("R6 ready ignored", act_n, 4);
        iordy = 1'b1;

        // R7: timeout cap
        cfg(2'd0, 16'h0180);
        iordy = 1'b0;
        xfer(1'b0, 1'b0, 0, 1'b0);
        check("R7 capped active", act_n, 2 + STALL); check("R7 recovery", rec_n, 1);
        check("R7 err with done", err_seen, 1);
        iordy = 1'b1;

        // R9: request and write during transfer
        cfg(2'd0, 16'h0402);
        xfer(1'b0, 1'b0, 0, 1'b1);
        check("R9 active unchanged", act_n, 5); check("R9 recovery unchanged", rec_n, 3);
        repeat (2) begin
            @(negedge clk);
            check("R9 busy request ignored", busy, 0);
        end
        xfer(1'b0, 1'b0, 0, 1'b0);
        check("R9 new word active", act_n, 1); check("R3 new word recovery", rec_n, 1);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired, got busy=%b expected idle", busy);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule